// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the raster timing for a 50 Hz, PAL-style display that interlaces two fields. A 2 MHz enable drives it. On each enable the horizontal position moves forward by eight pixel-clock units. The block tracks the line, the field and the character row within a text or graphics row. From that position it derives the horizontal sync, the vertical sync, the colour-burst window and the blanking signal. Vertical sync starts and ends half a line apart on the two fields, which is what offsets one field from the other.

The same position also produces two interrupt events, each one enable period long: a real-time-clock tick once per field and a display-end event after the last visible line. An external status register latches them. The block also tells the CPU bus how many 2 MHz cycles an access issued now will stall. I/O accesses wait for the slow-bus phase. RAM accesses in 80-column modes also wait out the rest of the active pixel fetch.

Mode flags select text or graphics (which sets the visible line count and character-row height) and 40 or 80 columns (which decides whether pixel fetch blocks RAM).

Top module: `raster_timing`

## Requirements
- R1: While `tick` is high, `h_pos` advances by 8 on each rising clock edge, and wraps from 1016 to 0. It holds when `tick` is low. Reset clears all counters, syncs and pulses to 0.
- R2: At the tick that leaves h=1016 on the last line of a field, `v_pos` returns to 0 and `field` toggles. Otherwise `v_pos` increments there. The last line is 311 when `field`=0 and 310 when `field`=1.
- R3: `hsync` goes high after the tick taken at h=768 and goes low after the tick taken at h=832.
- R4: When `field`=0, `vsync` goes high after the tick at (line 274, h=0) and low after the tick at (line 276, h=512). When `field`=1, it goes high after the tick at (line 274, h=512) and low after the tick at (line 277, h=0).
- R5: `burst` is high exactly while 856 ≤ `h_pos` ≤ 895.
- R6: `blank` is high while `h_pos` ≥ 640, or `v_pos` ≥ 256 (graphics) or ≥ 250 (text), or `char_row` ≥ 8.
- R7: `char_row` changes only on the tick taken at h=832. It becomes 0 on the last line of a field, or after 7 in graphics or 9 in text, and otherwise increments. In graphics mode its bit 3 is always 0.
- R8: `irq_rtc` is set by the tick at line 99: at h=0 when `field`=0, or at h=512 when `field`=1.
- R9: `irq_disp_end` is set by the tick at h=768 on line 255 (graphics) or line 249 (text).
- R10: `io_stall` equals 2 plus bit 3 of `h_pos`.
- R11: `ram_stall` equals 2 + ((640 − `h_pos`) >> 3) when `col80` is high and `blank` is low. Otherwise it equals `io_stall`.
- R12: Every registered output is computed from the position held before the tick. Each interrupt output stays high for exactly one enable period: it is set by one tick and cleared by the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 2 MHz enable; one raster step per high cycle |
| text_mode | input | 1 | 1 = text mode (10-line rows, 250 lines), 0 = graphics |
| col80 | input | 1 | 1 = 80-column mode (pixel fetch blocks RAM) |
| h_pos | output | 10 | Horizontal position in pixel-clock units |
| v_pos | output | 9 | Line within the current field |
| field | output | 1 | Current field |
| char_row | output | 4 | Line within the character row |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| burst | output | 1 | Colour-burst window |
| blank | output | 1 | Blanking |
| irq_rtc | output | 1 | Real-time-clock event, one enable period |
| irq_disp_end | output | 1 | Display-end event, one enable period |
| io_stall | output | 7 | 2 MHz cycles an I/O access issued now will take |
| ram_stall | output | 7 | 2 MHz cycles a RAM access issued now will take |

## Verification
The counters, both syncs, the character row and the two interrupt outputs pass through one register each. They take their new value at the first rising edge where `tick` is high, computed from the position held before that edge. `burst`, `blank` and both stall counts are combinational, so they follow the current position with no latency. The bench drives `tick` on falling edges and advances its behavioural model at the same moment. It compares every output at the next falling edge, which means each result is sampled in the first cycle it is due and in every idle cycle after it. The enable pattern leaves regular gaps, so outputs are also checked for holding their values between ticks. The runs cover both fields in graphics mode, then text 40-column and text 80-column.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Slow-bus wait: two cycles plus the phase of the 1 MHz slot.
  function automatic int io_wait(input logic slot_phase);
    return 2 + int'(slot_phase);
  endfunction

  // Wait for the remaining pixel fetch on the line, in enable steps.
  function automatic int fetch_wait(input int active_end, input int hpos, input int step_log2);
    return 2 + ((active_end - hpos) >>> step_log2);
  endfunction

  // Next value of the character row counter at the row boundary.
  function automatic int next_row(input int row, input int last_row, input logic field_end);
    if (field_end) return 0;
    if (row == last_row) return 0;
    return row + 1;
  endfunction

endpackage

// File: rtl/rtg_hcount.sv
module rtg_hcount #(
  parameter int HW      = 10,
  parameter int H_STEP  = 8,
  parameter int H_TOTAL = 1024,
  parameter int HS_ON   = 768,
  parameter int HS_OFF  = 832
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [HW-1:0] h,
  output logic          hsync,
  output logic          line_last
);
  localparam logic [HW-1:0] STEP_C = HW'(H_STEP);
  localparam logic [HW-1:0] LAST_C = HW'(H_TOTAL - H_STEP);
  localparam logic [HW-1:0] ON_C   = HW'(HS_ON);
  localparam logic [HW-1:0] OFF_C  = HW'(HS_OFF);

  assign line_last = (h == LAST_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h     <= '0;
      hsync <= 1'b0;
    end else if (tick) begin
      h <= line_last ? '0 : h + STEP_C;
      if (h == ON_C)       hsync <= 1'b1;
      else if (h == OFF_C) hsync <= 1'b0;
    end
  end
endmodule

// File: rtl/rtg_vcount.sv
module rtg_vcount
  import rtg_pkg::*;
#(
  parameter int HW        = 10,
  parameter int VW        = 9,
  parameter int RW        = 4,
  parameter int V_TOTAL0  = 312,
  parameter int V_TOTAL1  = 311,
  parameter int VS_ON     = 274,
  parameter int VS_OFF0   = 276,
  parameter int VS_OFF1   = 277,
  parameter int H_HALF    = 512,
  parameter int ROW_EDGE  = 832,
  parameter int ROWS_GFX  = 8,
  parameter int ROWS_TXT  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          text_mode,
  input  logic [HW-1:0] h,
  input  logic          line_last,
  output logic [VW-1:0] v,
  output logic          field,
  output logic          vsync,
  output logic [RW-1:0] row,
  output logic          field_last
);
  localparam logic [VW-1:0] END0_C  = VW'(V_TOTAL0 - 1);
  localparam logic [VW-1:0] END1_C  = VW'(V_TOTAL1 - 1);
  localparam logic [VW-1:0] VON_C   = VW'(VS_ON);
  localparam logic [VW-1:0] VOFF0_C = VW'(VS_OFF0);
  localparam logic [VW-1:0] VOFF1_C = VW'(VS_OFF1);
  localparam logic [HW-1:0] HALF_C  = HW'(H_HALF);
  localparam logic [HW-1:0] EDGE_C  = HW'(ROW_EDGE);
  localparam logic [RW-1:0] GMASK_C = RW'(ROWS_GFX - 1);

  logic          at_line_start;
  logic          at_half_line;
  logic          vs_set;
  logic          vs_clr;
  logic [RW-1:0] row_nxt;

  assign field_last    = (v == (field ? END1_C : END0_C));
  assign at_line_start = (h == '0);
  assign at_half_line  = (h == HALF_C);

  // Field 0 syncs on line boundaries at the start, field 1 on the half line.
  assign vs_set = (v == VON_C) && (field ? at_half_line : at_line_start);
  assign vs_clr = field ? (at_line_start && v == VOFF1_C)
                        : (at_half_line  && v == VOFF0_C);

  always_comb begin
    row_nxt = row;
    if (h == EDGE_C)
      row_nxt = RW'(next_row(int'(row), text_mode ? ROWS_TXT - 1 : ROWS_GFX - 1, field_last));
    if (!text_mode)
      row_nxt = row_nxt & GMASK_C;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v     <= '0;
      field <= 1'b0;
      vsync <= 1'b0;
      row   <= '0;
    end else if (tick) begin
      row <= row_nxt;
      if (vs_set)      vsync <= 1'b1;
      else if (vs_clr) vsync <= 1'b0;
      if (line_last) begin
        if (field_last) begin
          v     <= '0;
          field <= ~field;
        end else begin
          v <= v + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtg_events.sv
module rtg_events
  import rtg_pkg::*;
#(
  parameter int HW        = 10,
  parameter int VW        = 9,
  parameter int RW        = 4,
  parameter int SW        = 7,
  parameter int STEP_LOG  = 3,
  parameter int H_ACTIVE  = 640,
  parameter int H_HALF    = 512,
  parameter int HS_ON     = 768,
  parameter int BURST_ON  = 856,
  parameter int BURST_END = 896,
  parameter int RTC_LINE  = 99,
  parameter int GFX_LINES = 256,
  parameter int TXT_LINES = 250,
  parameter int ROWS_GFX  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          text_mode,
  input  logic          col80,
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  input  logic          field,
  input  logic [RW-1:0] row,
  output logic          irq_rtc,
  output logic          irq_disp_end,
  output logic          blank,
  output logic          burst,
  output logic [SW-1:0] io_stall,
  output logic [SW-1:0] ram_stall
);
  localparam logic [HW-1:0] ACT_C   = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HALF_C  = HW'(H_HALF);
  localparam logic [HW-1:0] DE_H_C  = HW'(HS_ON);
  localparam logic [HW-1:0] BON_C   = HW'(BURST_ON);
  localparam logic [HW-1:0] BEND_C  = HW'(BURST_END);
  localparam logic [VW-1:0] RTC_C   = VW'(RTC_LINE);
  localparam logic [VW-1:0] GLIM_C  = VW'(GFX_LINES);
  localparam logic [VW-1:0] TLIM_C  = VW'(TXT_LINES);
  localparam logic [RW-1:0] RLIM_C  = RW'(ROWS_GFX);

  logic [VW-1:0] vis_lines;
  logic          rtc_hit;
  logic          de_hit;

  assign vis_lines = text_mode ? TLIM_C : GLIM_C;
  assign blank     = (h >= ACT_C) || (v >= vis_lines) || (row >= RLIM_C);
  assign burst     = (h >= BON_C) && (h < BEND_C);

  assign rtc_hit = (v == RTC_C) && (field ? (h == HALF_C) : (h == '0));
  assign de_hit  = (h == DE_H_C) && (v == vis_lines - 1'b1);

  assign io_stall = SW'(io_wait(h[STEP_LOG]));

  always_comb begin
    if (col80 && !blank)
      ram_stall = SW'(fetch_wait(H_ACTIVE, int'(h), STEP_LOG));
    else
      ram_stall = io_stall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_rtc      <= 1'b0;
      irq_disp_end <= 1'b0;
    end else if (tick) begin
      irq_rtc      <= rtc_hit;
      irq_disp_end <= de_hit;
    end
  end
endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int H_STEP    = 8,
  parameter int H_TOTAL   = 1024,
  parameter int H_ACTIVE  = 640,
  parameter int H_HALF    = 512,
  parameter int HS_ON     = 768,
  parameter int HS_OFF    = 832,
  parameter int BURST_ON  = 856,
  parameter int BURST_END = 896,
  parameter int V_TOTAL0  = 312,
  parameter int V_TOTAL1  = 311,
  parameter int VS_ON     = 274,
  parameter int VS_OFF0   = 276,
  parameter int VS_OFF1   = 277,
  parameter int RTC_LINE  = 99,
  parameter int GFX_LINES = 256,
  parameter int TXT_LINES = 250,
  parameter int ROWS_GFX  = 8,
  parameter int ROWS_TXT  = 10,
  localparam int HW       = $clog2(H_TOTAL),
  localparam int VW       = $clog2(V_TOTAL0),
  localparam int RW       = $clog2(ROWS_TXT),
  localparam int SW       = $clog2(3 + H_ACTIVE / H_STEP),
  localparam int STEP_LOG = $clog2(H_STEP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          text_mode,
  input  logic          col80,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          field,
  output logic [RW-1:0] char_row,
  output logic          hsync,
  output logic          vsync,
  output logic          burst,
  output logic          blank,
  output logic          irq_rtc,
  output logic          irq_disp_end,
  output logic [SW-1:0] io_stall,
  output logic [SW-1:0] ram_stall
);
  // Named internal events, also observed by the bound checker.
  logic line_last;
  logic field_last;

  rtg_hcount #(
    .HW(HW), .H_STEP(H_STEP), .H_TOTAL(H_TOTAL), .HS_ON(HS_ON), .HS_OFF(HS_OFF)
  ) u_h (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .h(h_pos), .hsync(hsync), .line_last(line_last)
  );

  rtg_vcount #(
    .HW(HW), .VW(VW), .RW(RW), .V_TOTAL0(V_TOTAL0), .V_TOTAL1(V_TOTAL1),
    .VS_ON(VS_ON), .VS_OFF0(VS_OFF0), .VS_OFF1(VS_OFF1), .H_HALF(H_HALF),
    .ROW_EDGE(HS_OFF), .ROWS_GFX(ROWS_GFX), .ROWS_TXT(ROWS_TXT)
  ) u_v (
    .clk(clk), .rst_n(rst_n), .tick(tick), .text_mode(text_mode),
    .h(h_pos), .line_last(line_last),
    .v(v_pos), .field(field), .vsync(vsync), .row(char_row), .field_last(field_last)
  );

  rtg_events #(
    .HW(HW), .VW(VW), .RW(RW), .SW(SW), .STEP_LOG(STEP_LOG), .H_ACTIVE(H_ACTIVE),
    .H_HALF(H_HALF), .HS_ON(HS_ON), .BURST_ON(BURST_ON), .BURST_END(BURST_END),
    .RTC_LINE(RTC_LINE), .GFX_LINES(GFX_LINES), .TXT_LINES(TXT_LINES), .ROWS_GFX(ROWS_GFX)
  ) u_ev (
    .clk(clk), .rst_n(rst_n), .tick(tick), .text_mode(text_mode), .col80(col80),
    .h(h_pos), .v(v_pos), .field(field), .row(char_row),
    .irq_rtc(irq_rtc), .irq_disp_end(irq_disp_end), .blank(blank), .burst(burst),
    .io_stall(io_stall), .ram_stall(ram_stall)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int HW       = 10,
  parameter int VW       = 9,
  parameter int RW       = 4,
  parameter int SW       = 7,
  parameter int H_STEP   = 8,
  parameter int HS_ON    = 768,
  parameter int HS_OFF   = 832,
  parameter int VS_ON    = 274
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          text_mode,
  input logic [HW-1:0] h_pos,
  input logic [VW-1:0] v_pos,
  input logic          field,
  input logic [RW-1:0] char_row,
  input logic          hsync,
  input logic          vsync,
  input logic          irq_rtc,
  input logic          irq_disp_end,
  input logic [SW-1:0] io_stall,
  input logic [SW-1:0] ram_stall,
  input logic          line_last,
  input logic          field_last
);
  p_h_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !line_last) |=> (h_pos == $past(h_pos) + HW'(H_STEP)));

  p_h_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(h_pos) && $stable(v_pos) && $stable(field)));

  p_field_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (field != $past(field)) |-> ($past(line_last) && $past(field_last) && v_pos == '0));

  p_hsync_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> ($past(h_pos) == HW'(HS_ON)));

  p_hsync_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |-> ($past(h_pos) == HW'(HS_OFF)));

  p_vsync_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> ($past(v_pos) == VW'(VS_ON)));

  p_row_gfx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!text_mode && $past(tick)) |-> (char_row < RW'(8)));

  p_irq_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rtc && irq_disp_end));

  p_io_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_stall == SW'(2)) || (io_stall == SW'(3)));

  p_ram_floor_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_stall >= io_stall);

  p_pulse_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rtc && !tick) |=> irq_rtc);

  p_pulse_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_disp_end && tick) |=> !irq_disp_end);
endmodule

bind raster_timing raster_timing_chk #(
  .HW(HW), .VW(VW), .RW(RW), .SW(SW), .H_STEP(H_STEP),
  .HS_ON(HS_ON), .HS_OFF(HS_OFF), .VS_ON(VS_ON)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .text_mode(text_mode),
  .h_pos(h_pos), .v_pos(v_pos), .field(field), .char_row(char_row),
  .hsync(hsync), .vsync(vsync), .irq_rtc(irq_rtc), .irq_disp_end(irq_disp_end),
  .io_stall(io_stall), .ram_stall(ram_stall),
  .line_last(line_last), .field_last(field_last)
);

// File: tb/raster_timing_test.sv
module raster_timing_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic clk = 1'b0;
  logic rst_n, tick, text_mode, col80;
  logic [9:0] h_pos;
  logic [8:0] v_pos;
  logic       field;
  logic [3:0] char_row;
  logic       hsync, vsync, burst, blank, irq_rtc, irq_disp_end;
  logic [6:0] io_stall, ram_stall;

  always #(CLK_PERIOD / 2) clk = ~clk;

  raster_timing uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .text_mode(text_mode), .col80(col80),
    .h_pos(h_pos), .v_pos(v_pos), .field(field), .char_row(char_row),
    .hsync(hsync), .vsync(vsync), .burst(burst), .blank(blank),
    .irq_rtc(irq_rtc), .irq_disp_end(irq_disp_end),
    .io_stall(io_stall), .ram_stall(ram_stall)
  );

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;
  int cyc    = 0;

  // Reference state: the raster position and registered outputs.
  int mh = 0, mv = 0, mf = 0, mrow = 0;
  int mhs = 0, mvs = 0, mrtc = 0, mde = 0;

  task automatic chk(input string what, input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (h=%0d v=%0d f=%0d)",
               req, what, act, exp, mh, mv, mf);
    end
  endtask

  function automatic int exp_blank();
    int lim = text_mode ? 250 : 256;
    return (mh >= 640 || mv >= lim || mrow >= 8) ? 1 : 0;
  endfunction

  task automatic compare_all();
    int io_e, ram_e;
    io_e  = 2 + ((mh / 8) % 2);
    ram_e = (col80 && exp_blank() == 0) ? 2 + (640 - mh) / 8 : io_e;
    chk("h_pos", "R1", int'(h_pos), mh);
    chk("v_pos", "R2", int'(v_pos), mv);
    chk("field", "R2", int'(field), mf);
    chk("hsync", "R3", int'(hsync), mhs);
    chk("vsync", "R4", int'(vsync), mvs);
    chk("burst", "R5", int'(burst), (mh >= 856 && mh <= 895) ? 1 : 0);
    chk("blank", "R6", int'(blank), exp_blank());
    chk("char_row", "R7", int'(char_row), mrow);
    chk("irq_rtc", "R8", int'(irq_rtc), mrtc);
    chk("irq_disp_end", "R9", int'(irq_disp_end), mde);
    chk("io_stall", "R10", int'(io_stall), io_e);
    chk("ram_stall", "R11", int'(ram_stall), ram_e);
  endtask

  // One enable step, decided from the position before the step (R12).
  task automatic model_step();
    int last_line, row_top, disp_line;
    bit at_end;
    last_line = (mf == 1) ? 310 : 311;
    at_end    = (mv == last_line);
    row_top   = text_mode ? 9 : 7;
    disp_line = text_mode ? 249 : 255;

    mrtc = (mv == 99 && ((mf == 0 && mh == 0) || (mf == 1 && mh == 512))) ? 1 : 0;
    mde  = (mh == 768 && mv == disp_line) ? 1 : 0;

    if (mh == 768)      mhs = 1;
    else if (mh == 832) mhs = 0;

    if (mf == 0) begin
      if (mv == 274 && mh == 0)        mvs = 1;
      else if (mv == 276 && mh == 512) mvs = 0;
    end else begin
      if (mv == 274 && mh == 512)      mvs = 1;
      else if (mv == 277 && mh == 0)   mvs = 0;
    end

    if (mh == 832) begin
      if (at_end || mrow == row_top) mrow = 0;
      else mrow = mrow + 1;
    end
    if (!text_mode) mrow = mrow % 8;

    mh = (mh + 8) % 1024;
    if (mh == 0) begin
      if (at_end) begin
        mv = 0;
        mf = 1 - mf;
      end else begin
        mv = mv + 1;
      end
    end
  endtask

  task automatic run_ticks(input int n, input bit txt, input bit wide);
    int applied = 0;
    @(negedge clk);
    compare_all();
    text_mode = txt;
    col80     = wide;
    tick      = 1'b0;
    while (applied < n) begin
      @(negedge clk);
      compare_all();
      cyc++;
      if ((cyc % 7) != 6) begin
        model_step();
        tick = 1'b1;
        applied++;
      end else begin
        tick = 1'b0;
      end
    end
    @(negedge clk);
    compare_all();
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    tick      = 1'b0;
    text_mode = 1'b0;
    col80     = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state, R1: all counters, syncs and pulses cleared.
    compare_all();
    rst_n = 1'b1;
    // Graphics, 80 columns: both fields, both vsync shapes, both RTC points.
    run_ticks(80000, 1'b0, 1'b1);
    // Text, 40 columns: 10-line rows, 250 visible lines, line-249 display end.
    run_ticks(42000, 1'b1, 1'b0);
    // Text, 80 columns: RAM stall across blank row lines.
    run_ticks(8000, 1'b1, 1'b1);
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule